// File: doc/BRIEF.md
# Token-Passing Readout Controller with Trigger Stack

This block sits between the trigger path and a daisy chain of pixel readout chips. Every level-1 trigger pulse is numbered and parked in a 32-entry first-in first-out stack. Events leave the stack one at a time. For each one the controller sends a 28-bit header on a serial line, hands a one-cycle token to the first chip of the chain, waits for the token to come back from the last chip, and then sends a 28-bit trailer. Both frames are built in a single shift register and leave most significant bit first, with a valid strobe high for every frame bit.

A programmable timer limits how long the controller waits for the returned token. When the timer runs out, the event is truncated: the trailer goes out anyway and carries a truncation flag. If the stack fills up, the controller stops handing out tokens for the excess events. A trigger that arrives with 16 or more events already waiting is still numbered and framed, but it gets no token. A trigger that arrives with 32 events waiting is dropped, and the next trailer reports the overflow.

Top module: `rdo_token_ctrl`

## Requirements
- R1: After synchronous reset, `valid_o` and `tok_out_o` are low, the stack is empty and no frame is sent until a trigger arrives.
- R2: A header is 28 bits sent MSB first: marker 011111111100 (bits 27:16), the event number (bits 15:8), then the number of events still waiting in the stack when this event was taken out (bits 7:0).
- R3: The first accepted trigger after reset gets event number 1. Each later accepted trigger gets the previous number plus one, wrapping from 255 to 0. A dropped trigger uses up no number.
- R4: For an event that is read out, `tok_out_o` is high for exactly one cycle, in the cycle right after the last header bit, and `valid_o` is low in that cycle.
- R5: The first trailer bit is on `ser_o` in the cycle after `tok_in_i` is sampled high. The trailer is marker 011111111111 (bits 27:16), a flag byte (bits 15:8) and `status_i` as sampled in the cycle the trailer starts (bits 7:0). Flag bits 4:0 are always zero.
- R6: If `tok_in_i` stays low, the first trailer bit appears `timeout_i`+2 cycles after the cycle in which `tok_out_o` was high, and flag bit 7 (truncated) is set.
- R7: Events are read out in trigger order. Triggers spaced 15 cycles apart each get their own header with consecutive event numbers and one token pass each.
- R8: A trigger that arrives when 16 or more events are already waiting is stored with readout suppressed. Its header is followed, with no gap, by its trailer. No token is issued for it, and flag bit 6 is set.
- R9: A trigger that arrives when 32 events are waiting is dropped. Flag bit 5 is set in the next trailer that starts after the drop, and it is clear in later trailers unless another drop happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Level-1 trigger, one pulse per event |
| tok_in_i | input | 1 | Token returned from the end of the chip chain |
| timeout_i | input | TMR_W | Maximum cycles to wait for the returned token |
| status_i | input | 8 | Status byte placed in each trailer |
| tok_out_o | output | 1 | Token pulse to the first chip of the chain |
| ser_o | output | 1 | Serial header/trailer data, MSB first |
| valid_o | output | 1 | High for every frame bit on `ser_o` |

## Verification
A wrong stack count or pointer in this block shows up within one frame. It appears as a wrong event number or stack-count byte in the very next header, or as headers arriving in the wrong order. A wrong sequencer state shows up within a cycle or two as a token pulse that is missing, doubled or out of place, or as a gap between header and trailer. A corrupted timer or flag register shows only at the next trailer, as a trailer that starts in the wrong cycle or as a wrong flag bit. For that reason each scenario decodes every frame it causes and checks the cycle distances between token, token return and trailer.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int MARK_W   = 12;
    localparam int BYTE_W   = 8;
    localparam int FRAME_W  = MARK_W + 2 * BYTE_W;
    localparam int BITCNT_W = $clog2(FRAME_W);

    localparam logic [MARK_W-1:0] HDR_MARK = 12'b0111_1111_1100;
    localparam logic [MARK_W-1:0] TRL_MARK = 12'b0111_1111_1111;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic  no_rd;
        byte_t evt;
    } slot_t;

    typedef struct packed {
        logic       trunc;
        logic       no_rd;
        logic       ovf;
        logic [4:0] zero;
    } tflags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TOKEN,
        ST_WAIT,
        ST_TRL
    } rd_state_t;

    function automatic frame_t hdr_word(input byte_t evt, input byte_t waiting);
        return {HDR_MARK, evt, waiting};
    endfunction

    function automatic frame_t trl_word(input tflags_t flg, input byte_t stat);
        return {TRL_MARK, flg, stat};
    endfunction

endpackage

// File: rtl/rdo_trig_stack.sv
module rdo_trig_stack
    import rdo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LIMIT = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       trig_i,
    input  logic                       pop_i,
    input  logic                       ovf_clr_i,
    output slot_t                      head_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       ovf_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    slot_t             mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    byte_t             evt_q;
    logic              ovf_q;
    logic              full, accept, drop, do_pop;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign accept = trig_i && !full;
    assign drop   = trig_i && full;
    assign do_pop = pop_i && (cnt_q != '0);

    always_ff @(posedge clk_i) begin
        if (accept) begin
            mem[wp_q].no_rd <= (cnt_q >= CNT_W'(LIMIT));
            mem[wp_q].evt   <= evt_q + 8'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            evt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (accept) begin
                wp_q  <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
                evt_q <= evt_q + 8'd1;
            end
            if (do_pop)
                rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(do_pop);
            ovf_q <= (ovf_q && !ovf_clr_i) || drop;
        end
    end

    assign head_o = mem[rp_q];
    assign cnt_o  = cnt_q;
    assign ovf_o  = ovf_q;

    // R7: occupancy never exceeds the stack depth
    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CNT_W'(DEPTH));

    // R9: a trigger on a full stack with no pop leaves it full and raises overflow
    a_r9_drop_keeps_full: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig_i && full && !pop_i) |=> (full && ovf_q));

    // R3: event numbering advances by one per accepted trigger only
    a_r3_evt_step: assert property (@(posedge clk_i) disable iff (rst_i)
        accept |=> (evt_q == $past(evt_q) + 8'd1));
    a_r3_evt_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!trig_i || full) |=> $stable(evt_q));

endmodule

// File: rtl/rdo_frame_shift.sv
module rdo_frame_shift
    import rdo_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   load_i,
    input  frame_t word_i,
    input  logic   shift_i,
    output logic   msb_o
);
    frame_t sreg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            sreg_q <= '0;
        else if (load_i)
            sreg_q <= word_i;
        else if (shift_i)
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
    end

    assign msb_o = sreg_q[FRAME_W-1];

    // R2: each shift moves the next lower bit into the output position
    a_r2_shift_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_i && !load_i) |=> (sreg_q[FRAME_W-1] == $past(sreg_q[FRAME_W-2])));

endmodule

// File: rtl/rdo_token_timer.sv
module rdo_token_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)
            tmr_q <= '0;
        else if (!expired_o)
            tmr_q <= tmr_q + TMR_W'(1);
    end

    assign expired_o = (tmr_q >= limit_i);

    // R6: while waiting and not yet expired, the timer counts every cycle
    a_r6_timer_counts: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && !expired_o) |=> (tmr_q == $past(tmr_q) + TMR_W'(1)));

endmodule

// File: rtl/rdo_token_ctrl.sv
module rdo_token_ctrl
    import rdo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LIMIT = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trig_i,
    input  logic             tok_in_i,
    input  logic [TMR_W-1:0] timeout_i,
    input  logic [7:0]       status_i,
    output logic             tok_out_o,
    output logic             ser_o,
    output logic             valid_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

    rd_state_t            st_q, st_d;
    logic [BITCNT_W-1:0]  bit_q;
    logic                 no_rd_q;
    slot_t                head;
    logic [CNT_W-1:0]     cnt;
    logic                 ovf;
    logic                 pop, load, shift, ovf_clr, expired, last_bit;
    frame_t               word;
    tflags_t              flg;

    rdo_trig_stack #(.DEPTH(DEPTH), .LIMIT(LIMIT)) u_stack (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .trig_i    (trig_i),
        .pop_i     (pop),
        .ovf_clr_i (ovf_clr),
        .head_o    (head),
        .cnt_o     (cnt),
        .ovf_o     (ovf)
    );

    rdo_frame_shift u_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .word_i  (word),
        .shift_i (shift),
        .msb_o   (ser_o)
    );

    rdo_token_timer #(.TMR_W(TMR_W)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (st_q != ST_WAIT),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    assign last_bit = (bit_q == LAST_BIT);

    always_comb begin
        st_d    = st_q;
        pop     = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        ovf_clr = 1'b0;
        word    = '0;
        flg     = '{trunc: 1'b0, no_rd: no_rd_q, ovf: ovf, zero: 5'd0};
        unique case (st_q)
            ST_IDLE: begin
                if (cnt != '0) begin
                    pop  = 1'b1;
                    load = 1'b1;
                    word = hdr_word(head.evt, byte_t'(cnt - CNT_W'(1)));
                    st_d = ST_HDR;
                end
            end
            ST_HDR: begin
                shift = 1'b1;
                if (last_bit) begin
                    if (no_rd_q) begin
                        load    = 1'b1;
                        ovf_clr = 1'b1;
                        word    = trl_word(flg, status_i);
                        st_d    = ST_TRL;
                    end else begin
                        st_d = ST_TOKEN;
                    end
                end
            end
            ST_TOKEN: st_d = ST_WAIT;
            ST_WAIT: begin
                if (tok_in_i || expired) begin
                    flg.trunc = !tok_in_i;
                    load      = 1'b1;
                    ovf_clr   = 1'b1;
                    word      = trl_word(flg, status_i);
                    st_d      = ST_TRL;
                end
            end
            ST_TRL: begin
                shift = 1'b1;
                if (last_bit)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            no_rd_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load)
                bit_q <= '0;
            else if (shift)
                bit_q <= bit_q + BITCNT_W'(1);
            if (pop)
                no_rd_q <= head.no_rd;
        end
    end

    assign valid_o   = (st_q == ST_HDR) || (st_q == ST_TRL);
    assign tok_out_o = (st_q == ST_TOKEN);

    // R4: the token is a single-cycle pulse and never overlaps frame data
    a_r4_token_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        tok_out_o |=> !tok_out_o);
    a_r4_token_no_data: assert property (@(posedge clk_i) disable iff (rst_i)
        !(tok_out_o && valid_o));
    a_r4_token_after_hdr: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_HDR && last_bit && !no_rd_q) |=> tok_out_o);

    // R5: a returned token starts the trailer on the next cycle
    a_r5_trl_on_return: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_WAIT && tok_in_i) |=> (valid_o && st_q == ST_TRL));

    // R6: an expired timer ends the wait
    a_r6_timeout_exit: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_WAIT && expired) |=> (st_q == ST_TRL));

    // R8: a suppressed event goes straight from header to trailer
    a_r8_no_token: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_HDR && last_bit && no_rd_q) |=> (valid_o && !tok_out_o));

endmodule

// File: tb/rdo_token_ctrl_tb_top.sv
module rdo_token_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        tok_in = 1'b0;
    logic [15:0] timeout = 16'd200;
    logic [7:0]  status = 8'hA5;
    logic        tok_out, ser, valid;

    always #2 clk = ~clk;   // 250 MHz

    rdo_token_ctrl dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .trig_i    (trig),
        .tok_in_i  (tok_in),
        .timeout_i (timeout),
        .status_i  (status),
        .tok_out_o (tok_out),
        .ser_o     (ser),
        .valid_o   (valid)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [27:0] words [0:1023];
    int wstart [0:1023];
    int wend   [0:1023];
    int tok_at [0:1023];
    int nw = 0, ntok = 0, cyc = 0, bc = 0, cur_start = 0;
    logic [27:0] cur = '0;
    bit resp_en = 1'b1;
    int resp_delay = 4;
    int pend = -1;
    int exp_evt = 0;

    // frame monitor and token responder, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        tok_in = 1'b0;
        if (valid) begin
            if (bc == 0) cur_start = cyc;
            cur = {cur[26:0], ser};
            bc++;
            if (bc == 28) begin
                words[nw] = cur; wstart[nw] = cur_start; wend[nw] = cyc;
                nw++; bc = 0;
            end
        end
        if (tok_out) begin
            tok_at[ntok] = cyc; ntok++;
            if (resp_en) pend = resp_delay;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin tok_in = 1'b1; pend = -1; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic wait_words(input int n);
        while (nw < n) @(negedge clk);
    endtask

    task automatic one_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    function automatic int hdr_exp(input int evt, input int waiting);
        return (12'h7FC << 16) | ((evt & 8'hFF) << 8) | waiting;
    endfunction

    function automatic int trl_exp(input int flags, input int stat);
        return (12'h7FF << 16) | (flags << 8) | stat;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1", "valid after reset", int'(valid), 0);
        chk("R1", "token after reset", int'(tok_out), 0);
        chk("R1", "frames before any trigger", nw, 0);
    endtask

    task automatic t_single();
        int b = nw, t = ntok;
        resp_en = 1; resp_delay = 4; status = 8'hA5;
        one_trig(); exp_evt++;
        wait_words(b + 2);
        chk("R2", "header word", int'(words[b]), hdr_exp(exp_evt, 0));
        chk("R3", "first event number", int'(words[b][15:8]), 1);
        chk("R4", "token pulses", ntok - t, 1);
        chk("R4", "token after header", tok_at[t], wend[b] + 1);
        chk("R5", "trailer word", int'(words[b+1]), trl_exp(0, 8'hA5));
        chk("R5", "trailer start after return", wstart[b+1], tok_at[t] + resp_delay + 1);
    endtask

    task automatic t_spaced();
        int b = nw, t = ntok;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            repeat (14) @(negedge clk);
        end
        wait_words(b + 6);
        chk("R7", "spaced header 0", int'(words[b]),   hdr_exp(exp_evt + 1, 0));
        chk("R7", "spaced header 1", int'(words[b+2]), hdr_exp(exp_evt + 2, 1));
        chk("R7", "spaced header 2", int'(words[b+4]), hdr_exp(exp_evt + 3, 0));
        chk("R7", "spaced token passes", ntok - t, 3);
        exp_evt += 3;
    endtask

    task automatic t_timeout();
        int b = nw, t = ntok;
        resp_en = 0; timeout = 16'd20; status = 8'h3C;
        one_trig(); exp_evt++;
        wait_words(b + 2);
        chk("R6", "truncated header", int'(words[b]), hdr_exp(exp_evt, 0));
        chk("R6", "truncated trailer flags", int'(words[b+1]), trl_exp(8'h80, 8'h3C));
        chk("R6", "trailer start after timeout", wstart[b+1], tok_at[t] + 20 + 2);
        resp_en = 1; timeout = 16'd200; status = 8'hA5;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_burst();
        int b = nw, t = ntok, e;
        resp_delay = 10;
        one_trig(); exp_evt++; e = exp_evt;
        while (!valid) @(negedge clk);
        trig = 1'b1;
        repeat (33) @(negedge clk);
        trig = 1'b0;
        wait_words(b + 66);
        chk("R9", "overflow flag in next trailer", int'(words[b+1]), trl_exp(8'h20, 8'hA5));
        for (int k = 1; k <= 32; k++) begin
            chk("R8", $sformatf("burst header %0d", k), int'(words[b+2*k]), hdr_exp(e + k, 32 - k));
            chk(k <= 16 ? "R9" : "R8", $sformatf("burst trailer %0d", k), int'(words[b+2*k+1]),
                trl_exp(k <= 16 ? 0 : 8'h40, 8'hA5));
        end
        chk("R8", "suppressed header-trailer gap", wstart[b+65], wend[b+64] + 1);
        chk("R8", "token passes in burst", ntok - t, 17);
        exp_evt += 32;
        resp_delay = 4;
    endtask

    task automatic t_wrap();
        resp_delay = 1;
        while (exp_evt < 256) begin
            int b = nw;
            one_trig(); exp_evt++;
            wait_words(b + 2);
        end
        chk("R3", "event number 255", int'(words[nw-4][15:8]), 255);
        chk("R3", "event number wraps to 0", int'(words[nw-2][15:8]), 0);
        chk("R1", "idle after last frame", int'(valid), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_spaced();
        t_timeout();
        t_burst();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule